// File: doc/BRIEF.md
# Video-Mode Line Blanking Sequencer

This block drives the transmit side of a serial display link running in video mode. For every line of a frame it decides which packets go out (line-start sync, blanking filler, pixel payload) and which state the lanes take during each horizontal porch and during vertical blanking. Those states are high-speed, low-power with the clock lane running, or low-power with the clock lane stopped. It emits one schedule item at a time through a valid/ready interface to a lane layer. The lane layer performs the serialisation, the lane transitions and the packet framing.

Each horizontal porch and the vertical blanking interval has its own selection bit. A 1 fills the period with a high-speed blanking packet whose payload is all zeros. A 0 places the lanes in the low-power state for that period. The data lanes must drop to low power at least once per frame, so the first sync-width line of vertical blanking is always spent in low power, even when every selection bit asks for high speed. A separate clock-run input decides whether the clock lane keeps toggling during low-power periods.

Timing and mode inputs are captured at the start of each frame. Changes made during a frame therefore apply only from the next frame boundary. All counts are in byte-clock cycles. No check is made that a low-power period is long enough for the lane transitions.

Top module: `video_blank_seq`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `out_valid` is 0. The first item offered after reset is a line-start sync packet (type code 0, word count 0), which belongs to the first line of the frame.
- R2: An active line is emitted as five items in this order: sync (type 0), sync-width porch, back porch, pixel packet (type 2, word count equal to the active byte count), front porch. The front porch of a line is therefore directly followed by the next line's sync.
- R3: Every vertical blanking line is emitted as a sync item followed by one blanking item. The word count of that blanking item is sync-width + back porch + active bytes + front porch.
- R4: A frame consists of the vertical sync-width lines, then the vertical back-porch lines, then the active lines, then the vertical front-porch lines. A region with a line count of zero is skipped. The vertical sync-width count must be at least 1. Every line, blanking or active, starts with exactly one sync item.
- R5: For each porch and for vertical blanking, a selection bit of 1 yields a high-speed blanking packet (type 1, lane code 0). A selection bit of 0 yields a low-power idle item (type 3) with a lane code other than 0.
- R6: The blanking item on the first vertical sync-width line is always low power (type 3). With all selection bits at 1, a frame contains exactly one low-power item.
- R7: A low-power item carries lane code 1 when the clock-run input is 1 and lane code 2 when it is 0. Lane code 3 never appears.
- R8: Once `out_valid` has risen it stays high. While `out_ready` is low the offered item does not change.
- R9: Changes to the timing, selection or clock-run inputs made during a frame do not alter any item of that frame. They apply from the first item of the next frame.
- R10: Sync, blanking-packet and pixel items always carry lane code 0. A sync item always carries word count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | byte clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_hsa | input | HW (12) | horizontal sync-width in bytes |
| cfg_hbp | input | HW (12) | horizontal back porch in bytes |
| cfg_hfp | input | HW (12) | horizontal front porch in bytes |
| cfg_act_bytes | input | HW (12) | pixel bytes per active line |
| cfg_vsa | input | VW (11) | vertical sync-width lines, at least 1 |
| cfg_vbp | input | VW (11) | vertical back-porch lines |
| cfg_vact | input | VW (11) | active lines |
| cfg_vfp | input | VW (11) | vertical front-porch lines |
| cfg_hsa_hs | input | 1 | 1: sync-width porch as HS blanking packet, 0: low power |
| cfg_hbp_hs | input | 1 | 1: back porch as HS blanking packet, 0: low power |
| cfg_hfp_hs | input | 1 | 1: front porch as HS blanking packet, 0: low power |
| cfg_vbl_hs | input | 1 | 1: vertical blanking as HS blanking packets, 0: low power |
| cfg_clk_run | input | 1 | 1: clock lane runs through low-power periods, 0: it stops |
| out_valid | output | 1 | an item is offered |
| out_ready | input | 1 | the lane layer accepts the offered item |
| out_pkt_type | output | 2 | 0 sync, 1 blanking packet, 2 pixel packet, 3 low-power idle |
| out_wc | output | HW+2 (14) | payload bytes, or the length of a low-power period |
| out_lane | output | 2 | 0 high speed, 1 low power with clock, 2 low power clock stopped |

## Verification
The bench goes after the once-per-frame forced low-power excursion on the first sync-width line. A design that drops it would send an all-high-speed frame with no low-power item at all. A design that misplaces it would put the excursion on the wrong line or repeat it on every blanking line. Zero-length vertical back and front porches are tested because a region walker that fails to skip them hangs on a zero count or emits phantom lines. Each such line adds a sync that the bench's per-frame sync count catches. The bench changes the inputs in the middle of a frame, because a design without frame-boundary capture would alter word counts within the frame. It also applies back-pressure and clock-stop settings, which expose items that change while stalled and a lane code that ignores the clock-run input.

// File: rtl/vls_pkg.sv
package vls_pkg;
  // schedule item kinds
  localparam logic [1:0] PKT_SYNC   = 2'd0;
  localparam logic [1:0] PKT_BLANK  = 2'd1;
  localparam logic [1:0] PKT_PIXEL  = 2'd2;
  localparam logic [1:0] PKT_LPIDLE = 2'd3;
  // lane states
  localparam logic [1:0] LANE_HS    = 2'd0;
  localparam logic [1:0] LANE_LP    = 2'd1;
  localparam logic [1:0] LANE_LPOFF = 2'd2;
  // vertical regions, in frame order
  localparam logic [1:0] RG_VSA = 2'd0;
  localparam logic [1:0] RG_VBP = 2'd1;
  localparam logic [1:0] RG_ACT = 2'd2;
  localparam logic [1:0] RG_VFP = 2'd3;
endpackage

// File: rtl/vls_cfg_shadow.sv
module vls_cfg_shadow #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [HW-1:0] in_hsa,
  input  logic [HW-1:0] in_hbp,
  input  logic [HW-1:0] in_hfp,
  input  logic [HW-1:0] in_act,
  input  logic [VW-1:0] in_vsa,
  input  logic [VW-1:0] in_vbp,
  input  logic [VW-1:0] in_vact,
  input  logic [VW-1:0] in_vfp,
  input  logic [4:0]    in_flags,
  output logic [HW-1:0] sh_hsa,
  output logic [HW-1:0] sh_hbp,
  output logic [HW-1:0] sh_hfp,
  output logic [HW-1:0] sh_act,
  output logic [VW-1:0] sh_vsa,
  output logic [VW-1:0] sh_vbp,
  output logic [VW-1:0] sh_vact,
  output logic [VW-1:0] sh_vfp,
  output logic [4:0]    sh_flags
);
  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [VW-1:0] V_ONE = VW'(1);

  // flags: {clk_run, vbl_hs, hsa_hs, hbp_hs, hfp_hs}; all reset to 1
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_hsa   <= H_ONE;
      sh_hbp   <= H_ONE;
      sh_hfp   <= H_ONE;
      sh_act   <= H_ONE;
      sh_vsa   <= V_ONE;
      sh_vbp   <= V_ONE;
      sh_vact  <= V_ONE;
      sh_vfp   <= V_ONE;
      sh_flags <= '1;
    end else if (load) begin
      sh_hsa   <= in_hsa;
      sh_hbp   <= in_hbp;
      sh_hfp   <= in_hfp;
      sh_act   <= in_act;
      sh_vsa   <= in_vsa;
      sh_vbp   <= in_vbp;
      sh_vact  <= in_vact;
      sh_vfp   <= in_vfp;
      sh_flags <= in_flags;
    end
  end
endmodule

// File: rtl/vls_vert_ctr.sv
module vls_vert_ctr
  import vls_pkg::*;
#(
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [VW-1:0] vsa,
  input  logic [VW-1:0] vbp,
  input  logic [VW-1:0] vact,
  input  logic [VW-1:0] vfp,
  output logic [1:0]    region,
  output logic          first_vsa,
  output logic          frame_last
);
  localparam int NRG = 4;
  localparam logic [VW-1:0] V_ONE = VW'(1);

  logic [VW-1:0] line_q;
  logic [VW-1:0] len [NRG];
  logic          found;
  logic [1:0]    nrg;
  logic          line_end;

  assign len[0] = vsa;
  assign len[1] = vbp;
  assign len[2] = vact;
  assign len[3] = vfp;

  // next non-empty region after the current one
  always_comb begin
    found = 1'b0;
    nrg   = RG_VSA;
    for (int k = 0; k < NRG; k++) begin
      if (!found && k > int'(region) && len[k] != '0) begin
        found = 1'b1;
        nrg   = 2'(k);
      end
    end
  end

  assign line_end   = (line_q == len[region] - V_ONE);
  assign frame_last = line_end && !found;
  assign first_vsa  = (region == RG_VSA) && (line_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      region <= RG_VSA;
      line_q <= '0;
    end else if (adv) begin
      if (!line_end) begin
        line_q <= line_q + V_ONE;
      end else if (found) begin
        region <= nrg;
        line_q <= '0;
      end else begin
        region <= RG_VSA;
        line_q <= '0;
      end
    end
  end
endmodule

// File: rtl/vls_line_seq.sv
module vls_line_seq
  import vls_pkg::*;
#(
  parameter int HW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            is_act,
  input  logic            force_lp,
  input  logic [HW-1:0]   hsa,
  input  logic [HW-1:0]   hbp,
  input  logic [HW-1:0]   hfp,
  input  logic [HW-1:0]   act,
  input  logic            hsa_hs,
  input  logic            hbp_hs,
  input  logic            hfp_hs,
  input  logic            vbl_hs,
  input  logic            clk_run,
  output logic [1:0]      pkt,
  output logic [HW+1:0]   wc,
  output logic [1:0]      lane,
  output logic            line_last
);
  localparam int WCW = HW + 2;
  localparam int SGW = 3;
  localparam logic [SGW-1:0] SEG_ACT_LAST = SGW'(4);
  localparam logic [SGW-1:0] SEG_BLK_LAST = SGW'(1);

  logic [SGW-1:0] seg;
  logic [WCW-1:0] blank_len;
  logic           porch;
  logic           hs_sel;
  logic [WCW-1:0] len_sel;
  logic [1:0]     lp_lane;

  assign blank_len = WCW'(hsa) + WCW'(hbp) + WCW'(act) + WCW'(hfp);
  assign lp_lane   = clk_run ? LANE_LP : LANE_LPOFF;
  assign line_last = is_act ? (seg == SEG_ACT_LAST) : (seg == SEG_BLK_LAST);

  always_comb begin
    pkt     = PKT_SYNC;
    wc      = '0;
    lane    = LANE_HS;
    porch   = 1'b0;
    hs_sel  = 1'b1;
    len_sel = '0;
    case (seg)
      3'd0: ;
      3'd1: begin
        porch = 1'b1;
        if (is_act) begin
          hs_sel  = hsa_hs;
          len_sel = WCW'(hsa);
        end else begin
          hs_sel  = vbl_hs && !force_lp;
          len_sel = blank_len;
        end
      end
      3'd2: begin
        porch   = 1'b1;
        hs_sel  = hbp_hs;
        len_sel = WCW'(hbp);
      end
      3'd3: begin
        pkt = PKT_PIXEL;
        wc  = WCW'(act);
      end
      default: begin
        porch   = 1'b1;
        hs_sel  = hfp_hs;
        len_sel = WCW'(hfp);
      end
    endcase
    if (porch) begin
      pkt  = hs_sel ? PKT_BLANK : PKT_LPIDLE;
      wc   = len_sel;
      lane = hs_sel ? LANE_HS : lp_lane;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       seg <= '0;
    else if (take) seg <= line_last ? '0 : seg + SGW'(1);
  end
endmodule

// File: rtl/video_blank_seq.sv
module video_blank_seq
  import vls_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HW-1:0]   cfg_hsa,
  input  logic [HW-1:0]   cfg_hbp,
  input  logic [HW-1:0]   cfg_hfp,
  input  logic [HW-1:0]   cfg_act_bytes,
  input  logic [VW-1:0]   cfg_vsa,
  input  logic [VW-1:0]   cfg_vbp,
  input  logic [VW-1:0]   cfg_vact,
  input  logic [VW-1:0]   cfg_vfp,
  input  logic            cfg_hsa_hs,
  input  logic            cfg_hbp_hs,
  input  logic            cfg_hfp_hs,
  input  logic            cfg_vbl_hs,
  input  logic            cfg_clk_run,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [1:0]      out_pkt_type,
  output logic [HW+1:0]   out_wc,
  output logic [1:0]      out_lane
);
  localparam int WCW = HW + 2;

  logic          primed;
  logic          take;
  logic          load;
  logic [HW-1:0] s_hsa, s_hbp, s_hfp, s_act;
  logic [VW-1:0] s_vsa, s_vbp, s_vact, s_vfp;
  logic [4:0]    s_flags;
  logic [1:0]    region;
  logic          first_vsa, frame_last, line_last;
  logic [1:0]    g_pkt, g_lane;
  logic [WCW-1:0] g_wc;

  // an item moves into the output register when it is empty or being taken
  assign take = primed && (!out_valid || out_ready);
  assign load = !primed || (take && line_last && frame_last);

  vls_cfg_shadow #(.HW(HW), .VW(VW)) u_shadow (
    .clk(clk), .rst(rst), .load(load),
    .in_hsa(cfg_hsa), .in_hbp(cfg_hbp), .in_hfp(cfg_hfp), .in_act(cfg_act_bytes),
    .in_vsa(cfg_vsa), .in_vbp(cfg_vbp), .in_vact(cfg_vact), .in_vfp(cfg_vfp),
    .in_flags({cfg_clk_run, cfg_vbl_hs, cfg_hsa_hs, cfg_hbp_hs, cfg_hfp_hs}),
    .sh_hsa(s_hsa), .sh_hbp(s_hbp), .sh_hfp(s_hfp), .sh_act(s_act),
    .sh_vsa(s_vsa), .sh_vbp(s_vbp), .sh_vact(s_vact), .sh_vfp(s_vfp),
    .sh_flags(s_flags)
  );

  vls_vert_ctr #(.VW(VW)) u_vert (
    .clk(clk), .rst(rst), .adv(take && line_last),
    .vsa(s_vsa), .vbp(s_vbp), .vact(s_vact), .vfp(s_vfp),
    .region(region), .first_vsa(first_vsa), .frame_last(frame_last)
  );

  vls_line_seq #(.HW(HW)) u_line (
    .clk(clk), .rst(rst), .take(take),
    .is_act(region == RG_ACT), .force_lp(first_vsa),
    .hsa(s_hsa), .hbp(s_hbp), .hfp(s_hfp), .act(s_act),
    .hsa_hs(s_flags[2]), .hbp_hs(s_flags[1]), .hfp_hs(s_flags[0]),
    .vbl_hs(s_flags[3]), .clk_run(s_flags[4]),
    .pkt(g_pkt), .wc(g_wc), .lane(g_lane), .line_last(line_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      primed       <= 1'b0;
      out_valid    <= 1'b0;
      out_pkt_type <= PKT_SYNC;
      out_wc       <= '0;
      out_lane     <= LANE_HS;
    end else begin
      primed <= 1'b1;
      if (take) begin
        out_valid    <= 1'b1;
        out_pkt_type <= g_pkt;
        out_wc       <= g_wc;
        out_lane     <= g_lane;
      end
    end
  end
endmodule

// File: rtl/vls_chk.sv
module vls_chk
  import vls_pkg::*;
#(
  parameter int WCW = 14
) (
  input logic           clk,
  input logic           rst,
  input logic           out_valid,
  input logic           out_ready,
  input logic [1:0]     out_pkt_type,
  input logic [WCW-1:0] out_wc,
  input logic [1:0]     out_lane
);
  logic after_pix;
  logic acc;
  assign acc = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst)      after_pix <= 1'b0;
    else if (acc) after_pix <= (out_pkt_type == PKT_PIXEL);
  end

  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pkt_type) && $stable(out_wc) && $stable(out_lane));

  // R8
  valid_keep_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  // R10
  hs_lane_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_pkt_type != PKT_LPIDLE |-> out_lane == LANE_HS);

  // R5
  lp_lane_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_pkt_type == PKT_LPIDLE |-> out_lane != LANE_HS);

  // R10
  sync_wc_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_pkt_type == PKT_SYNC |-> out_wc == '0);

  // R7
  lane_code_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_lane != 2'd3);

  // R2
  pix_then_porch_chk: assert property (@(posedge clk) disable iff (rst)
    acc && after_pix |-> out_pkt_type == PKT_BLANK || out_pkt_type == PKT_LPIDLE);
endmodule

bind video_blank_seq vls_chk #(.WCW(HW + 2)) u_vls_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_pkt_type(out_pkt_type), .out_wc(out_wc), .out_lane(out_lane)
);

// File: tb/video_blank_seq_test.sv
module video_blank_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int WD_LIMIT = 100000;
  localparam int NVEC = 6;
  // hsa hbp hfp act vsa vbp vact vfp hsa_hs hbp_hs hfp_hs vbl_hs clk_run backpressure
  localparam int VEC [0:NVEC-1][0:13] = '{
    '{4, 6, 5, 20, 2, 2, 3, 2, 1, 1, 1, 1, 1, 0},
    '{3, 4, 7, 16, 2, 1, 2, 3, 1, 1, 1, 0, 0, 0},
    '{5, 3, 2, 12, 1, 2, 2, 1, 0, 1, 0, 1, 0, 1},
    '{2, 2, 2, 8,  3, 0, 2, 0, 1, 1, 1, 1, 1, 1},
    '{1, 1, 1, 4,  1, 1, 1, 1, 0, 0, 0, 0, 1, 0},
    '{6, 2, 3, 10, 2, 1, 2, 1, 1, 1, 1, 1, 0, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HW-1:0] cfg_hsa = '0, cfg_hbp = '0, cfg_hfp = '0, cfg_act_bytes = '0;
  logic [VW-1:0] cfg_vsa = '0, cfg_vbp = '0, cfg_vact = '0, cfg_vfp = '0;
  logic cfg_hsa_hs = 1'b1, cfg_hbp_hs = 1'b1, cfg_hfp_hs = 1'b1, cfg_vbl_hs = 1'b1, cfg_clk_run = 1'b1;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [1:0] out_pkt_type, out_lane;
  logic [HW+1:0] out_wc;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int bp = 0;
  int seen = 0;
  int switch_at = -1;
  int nsync = 0;
  int nlp = 0;
  int sw_cfg [0:13];

  always #(CLK_PERIOD/2) clk = ~clk;

  video_blank_seq #(.HW(HW), .VW(VW)) uut (
    .clk(clk), .rst(rst),
    .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp), .cfg_act_bytes(cfg_act_bytes),
    .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .cfg_hsa_hs(cfg_hsa_hs), .cfg_hbp_hs(cfg_hbp_hs), .cfg_hfp_hs(cfg_hfp_hs),
    .cfg_vbl_hs(cfg_vbl_hs), .cfg_clk_run(cfg_clk_run),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pkt_type(out_pkt_type), .out_wc(out_wc), .out_lane(out_lane)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg(input int c [0:13]);
    cfg_hsa = HW'(c[0]); cfg_hbp = HW'(c[1]); cfg_hfp = HW'(c[2]); cfg_act_bytes = HW'(c[3]);
    cfg_vsa = VW'(c[4]); cfg_vbp = VW'(c[5]); cfg_vact = VW'(c[6]); cfg_vfp = VW'(c[7]);
    cfg_hsa_hs = c[8][0]; cfg_hbp_hs = c[9][0]; cfg_hfp_hs = c[10][0];
    cfg_vbl_hs = c[11][0]; cfg_clk_run = c[12][0];
    bp = c[13];
  endtask

  // R1: quiet during reset and during the capture cycle after it
  task automatic do_reset();
    rst = 1'b1;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in capture cycle", int'(out_valid), 0);
  endtask

  task automatic expect_item(input int ptype, input int wc, input int lane, input string req);
    bit got = 0;
    while (!got) begin
      @(negedge clk);
      cyc++;
      out_ready = (bp != 0 && (cyc % 3) == 1) ? 1'b0 : 1'b1;
      if (out_valid && out_ready) got = 1;
    end
    check(int'(out_pkt_type) == ptype, {req, " type"}, int'(out_pkt_type), ptype);
    check(int'(out_wc) == wc, {req, " word count"}, int'(out_wc), wc);
    check(int'(out_lane) == lane, {req, " lane"}, int'(out_lane), lane);
    if (out_pkt_type == 2'd0) nsync++;
    if (out_pkt_type == 2'd3) nlp++;
    seen++;
    if (seen == switch_at) apply_cfg(sw_cfg);
  endtask

  task automatic porch(input int hs, input int len, input int lpl, input string req);
    expect_item(hs != 0 ? 1 : 3, len, hs != 0 ? 0 : lpl, req);
  endtask

  task automatic run_frame(input int c [0:13]);
    int lpl = (c[12] != 0) ? 1 : 2;
    int blen = c[0] + c[1] + c[2] + c[3];
    int lines = c[4] + c[5] + c[6] + c[7];
    int exp_lp = 0;
    nsync = 0;
    nlp = 0;
    for (int l = 0; l < c[4]; l++) begin
      expect_item(0, 0, 0, "R4 vsa sync");
      // R6: first sync-width line is forced low power
      porch((l == 0) ? 0 : c[11], blen, lpl, (l == 0) ? "R6 forced lp" : "R3 vsa blank");
      exp_lp += (l == 0 || c[11] == 0) ? 1 : 0;
    end
    for (int l = 0; l < c[5]; l++) begin
      expect_item(0, 0, 0, "R4 vbp sync");
      porch(c[11], blen, lpl, "R3 vbp blank");
      exp_lp += (c[11] == 0) ? 1 : 0;
    end
    for (int l = 0; l < c[6]; l++) begin
      expect_item(0, 0, 0, "R2 act sync");
      porch(c[8], c[0], lpl, "R5 hsa porch");
      porch(c[9], c[1], lpl, "R5 hbp porch");
      expect_item(2, c[3], 0, "R2 pixel");
      porch(c[10], c[2], lpl, "R7 hfp porch");
      exp_lp += (c[8] == 0 ? 1 : 0) + (c[9] == 0 ? 1 : 0) + (c[10] == 0 ? 1 : 0);
    end
    for (int l = 0; l < c[7]; l++) begin
      expect_item(0, 0, 0, "R4 vfp sync");
      porch(c[11], blen, lpl, "R3 vfp blank");
      exp_lp += (c[11] == 0) ? 1 : 0;
    end
    check(nsync == lines, "R4 syncs per frame", nsync, lines);
    check(nlp == exp_lp, "R6 lp items per frame", nlp, exp_lp);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    int c_a [0:13];
    int c_b [0:13];
    logic [1:0] h_t;
    logic [1:0] h_l;
    logic [HW+1:0] h_w;

    for (int v = 0; v < NVEC; v++) begin
      apply_cfg(VEC[v]);
      do_reset();
      switch_at = -1;
      seen = 0;
      run_frame(VEC[v]);
    end

    // R9: change inputs mid-frame, the rest of the frame keeps the old values
    c_a = VEC[0];
    c_b = VEC[0];
    c_b[3] = 30; c_b[0] = 7; c_b[11] = 0; c_b[12] = 0;
    apply_cfg(c_a);
    do_reset();
    seen = 0;
    sw_cfg = c_b;
    switch_at = 3;
    run_frame(c_a);
    switch_at = -1;
    run_frame(c_b);
    run_frame(c_b);

    // R8: stalled item holds steady
    apply_cfg(VEC[2]);
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b1, "R8 valid after start", int'(out_valid), 1);
    check(out_pkt_type == 2'd0, "R1 first item sync", int'(out_pkt_type), 0);
    h_t = out_pkt_type; h_l = out_lane; h_w = out_wc;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b1 && out_pkt_type == h_t && out_lane == h_l && out_wc == h_w,
          "R8 hold under stall", int'(out_wc), int'(h_w));

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < WD_LIMIT; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WD_LIMIT, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule